// File: doc/BRIEF.md
# DDR2 Operating-Point Selector

This unit turns the raw timing bytes of one or two DDR2 memory modules into a single operating point that every present module can run at. That point is a speed grade, a CAS latency, and the row-to-column and precharge delays in clock cycles. Each module supplies four things: a CAS-latency bitmask, up to three clock-period codes, one tRCD byte and one tRP byte. The system supplies the fastest grade it allows and whether a second module is fitted. After a start pulse the unit works out its answer over a number of cycles. It then raises `done` for one cycle, together with either `ok` and the chosen timing, or `fail`.

The sequence is controlled by a state machine with six states:
- **S_IDLE**: waits for `start`.
- **S_PREP**: picks the next CAS latency / clock-period pairing of the current module and decodes its period. It can leave in four ways:
  - *next module*, staying in S_PREP;
  - *bad period*, going to S_FINISH;
  - *slots exhausted*, going to S_EVAL, or to S_FINISH when a module has no candidate;
  - *launch divide*, going to S_DIV_RCD.
- **S_DIV_RCD**: rounds tRCD up to whole cycles on a shared iterative subtractor. On *divide done* it moves to S_DIV_RP.
- **S_DIV_RP**: rounds tRP the same way and stores the candidate. On *divide done* it returns to S_PREP.
- **S_EVAL**: judges one candidate, or one merged pair of candidates, per clock and keeps the best. On *last pair* it moves to S_FINISH.
- **S_FINISH**: publishes the result and returns to S_IDLE.

Top module: `ddr2_bin_picker`

## Requirements
- R1: A clock-period code converts to a period in 10 ps units as 100 × (upper nibble) plus a term from the lower nibble. The term is 25 for 0xA, 33 for 0xB, 66 for 0xC, 75 for 0xD, and 10 × the nibble for any other value.
- R2: The speed grade is the fastest one whose period is not shorter than the decoded period. The limits are 250 for grade 3 (800), 300 for grade 2 (667), 375 for grade 1 (533) and 500 for grade 0 (400). `sel_grade` and `max_grade` use this encoding.
- R3: If any used clock-period code of a present module decodes to 0 or to more than 500, the result is `fail`.
- R4: The tRCD and tRP bytes count 0.25 ns steps. Their cycle counts are the ceiling of 25 × byte divided by the period of the candidate, so an exact multiple does not round up.
- R5: CAS latencies are taken by scanning mask bits 7 down to 2. At most the first N_SLOT set bits are used, highest first. The k-th one found is paired with clock code k, which sits at bits [8k+7:8k] of the `tck_*` port.
- R6: A candidate is rejected if its grade is above `max_grade`, if it is grade 3 while `two_mods` is set, or if its CAS latency is 3 or less.
- R7: With two modules, every candidate of module a is merged with every candidate of module b. The merge keeps module a's grade and CAS latency and takes the larger tRCD and the larger tRP.
- R8: A surviving candidate replaces the current choice in three cases: no choice exists yet, its grade is higher, or its grade is equal and its CL+tRCD+tRP sum is less than or equal to the current sum. Candidates are visited module-a slot outer, module-b slot inner.
- R9: If no candidate survives, or a present module has no latency bit set in 7..2, then `fail` is reported instead of a timing.
- R10: `done` is a one-cycle pulse per accepted start, and exactly one of `ok` and `fail` is high with it. The results stay unchanged until the next accepted start. A `start` that arrives while a run is in progress is ignored.
- R11: After reset, `done`, `ok` and `fail` are low and all timing outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a selection run (accepted only when idle) |
| two_mods | input | 1 | Second module is fitted |
| max_grade | input | 2 | Fastest grade the system allows |
| cas_mask_a | input | 8 | CAS-latency bitmask, module a |
| tck_a | input | 8*N_SLOT | Clock-period codes, module a, slot k at [8k+7:8k] |
| trcd_a | input | 8 | tRCD in 0.25 ns steps, module a |
| trp_a | input | 8 | tRP in 0.25 ns steps, module a |
| cas_mask_b | input | 8 | CAS-latency bitmask, module b |
| tck_b | input | 8*N_SLOT | Clock-period codes, module b |
| trcd_b | input | 8 | tRCD, module b |
| trp_b | input | 8 | tRP, module b |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | A timing was chosen |
| fail | output | 1 | No usable timing |
| sel_grade | output | 2 | Chosen speed grade |
| sel_cl | output | 4 | Chosen CAS latency |
| sel_rcd | output | LAT_W | Chosen tRCD in cycles |
| sel_rp | output | LAT_W | Chosen tRP in cycles |

## Verification
The bench builds the unit with its default of three slots per module. This covers the full three-entry latency scan, including masks with more than three set bits, and the full 3 × 3 pair walk with two modules. Clock codes are drawn from every fractional nibble code and from periods that fall exactly on a grade limit. This reaches the grade-limit comparisons, exact-multiple rounding, rejection by `max_grade`, and ties and orderings in the latency-sum preference.

// File: rtl/ddr2_bin_pkg.sv
package ddr2_bin_pkg;
    localparam int PER_W = 11;   // decoded period, 10 ps units (max 1650)
    localparam int LAT_W = 10;   // latency in cycles
    localparam int NUM_W = 14;   // 25 * byte
    localparam int SUM_W = LAT_W + 2;

    typedef struct packed {
        logic [1:0]       grade;
        logic [3:0]       cl;
        logic [LAT_W-1:0] rcd;
        logic [LAT_W-1:0] rp;
    } cand_t;
endpackage

// File: rtl/ddr2_tck_decode.sv
module ddr2_tck_decode
    import ddr2_bin_pkg::*;
(
    input  logic [7:0]       tck_code,
    output logic [PER_W-1:0] period,
    output logic [1:0]       grade,
    output logic             bad
);
    logic [PER_W-1:0] frac;

    always_comb begin
        unique case (tck_code[3:0])
            4'hA:    frac = PER_W'(25);
            4'hB:    frac = PER_W'(33);
            4'hC:    frac = PER_W'(66);
            4'hD:    frac = PER_W'(75);
            default: frac = PER_W'(tck_code[3:0]) * PER_W'(10);
        endcase
        period = PER_W'(tck_code[7:4]) * PER_W'(100) + frac;
        bad    = (period == '0) || (period > PER_W'(500));
        if (period <= PER_W'(250))      grade = 2'd3;
        else if (period <= PER_W'(300)) grade = 2'd2;
        else if (period <= PER_W'(375)) grade = 2'd1;
        else                            grade = 2'd0;
    end
endmodule

// File: rtl/ddr2_ceil_div.sv
module ddr2_ceil_div
    import ddr2_bin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [PER_W-1:0] den,
    output logic             fin,
    output logic [LAT_W-1:0] quo
);
    logic [NUM_W-1:0] rem_q, num_q;
    logic [PER_W-1:0] den_q;
    logic [LAT_W-1:0] quo_q;
    logic             busy_q;

    assign fin = busy_q && (rem_q == '0);
    assign quo = quo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            busy_q <= 1'b0;
        end else if (go) begin
            rem_q  <= num;
            num_q  <= num;
            den_q  <= den;
            quo_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (rem_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                if (rem_q > NUM_W'(den_q)) rem_q <= rem_q - NUM_W'(den_q);
                else                       rem_q <= '0;
                quo_q <= quo_q + 1'b1;
            end
        end
    end

    // R4: quotient is the exact ceiling of num/den
    a_r4_ceil_exact: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ((int'(quo_q) * int'(den_q) >= int'(num_q)) &&
                 ((quo_q == '0) || ((int'(quo_q) - 1) * int'(den_q) < int'(num_q)))));
endmodule

// File: rtl/ddr2_bin_judge.sv
module ddr2_bin_judge
    import ddr2_bin_pkg::*;
(
    input  cand_t      cand,
    input  cand_t      best,
    input  logic       have_best,
    input  logic [1:0] max_grade,
    input  logic       two_mods,
    output logic       take
);
    logic             reject;
    logic [SUM_W-1:0] sum_new, sum_best;

    always_comb begin
        sum_new  = SUM_W'(cand.cl) + SUM_W'(cand.rcd) + SUM_W'(cand.rp);
        sum_best = SUM_W'(best.cl) + SUM_W'(best.rcd) + SUM_W'(best.rp);
        reject   = (cand.grade > max_grade) ||
                   (two_mods && cand.grade == 2'd3) ||
                   (cand.cl <= 4'd3);
        take     = !reject &&
                   (!have_best ||
                    (cand.grade > best.grade) ||
                    ((cand.grade == best.grade) && (sum_new <= sum_best)));
    end
endmodule

// File: rtl/ddr2_bin_picker.sv
module ddr2_bin_picker
    import ddr2_bin_pkg::*;
#(
    parameter int N_SLOT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  two_mods,
    input  logic [1:0]            max_grade,
    input  logic [7:0]            cas_mask_a,
    input  logic [8*N_SLOT-1:0]   tck_a,
    input  logic [7:0]            trcd_a,
    input  logic [7:0]            trp_a,
    input  logic [7:0]            cas_mask_b,
    input  logic [8*N_SLOT-1:0]   tck_b,
    input  logic [7:0]            trcd_b,
    input  logic [7:0]            trp_b,
    output logic                  done,
    output logic                  ok,
    output logic                  fail,
    output logic [1:0]            sel_grade,
    output logic [3:0]            sel_cl,
    output logic [LAT_W-1:0]      sel_rcd,
    output logic [LAT_W-1:0]      sel_rp
);
    localparam int SLOT_W = $clog2(N_SLOT + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_PREP, S_DIV_RCD, S_DIV_RP, S_EVAL, S_FINISH
    } state_e;

    state_e state_q, state_d;

    logic              mod_q;
    logic [SLOT_W-1:0] slot_q;
    logic [PER_W-1:0]  per_q;
    logic [1:0]        grade_q;
    logic [3:0]        cl_q;
    logic [LAT_W-1:0]  rcd_q;
    cand_t             cand_q [2][N_SLOT];
    logic [SLOT_W-1:0] cnt_q  [2];
    logic [SLOT_W-1:0] ei_q, ej_q;
    logic              have_q, bad_q;
    cand_t             best_q;

    // ---- current module / slot selection ----
    function automatic logic [3:0] nth_cl(input logic [7:0] m, input int k);
        int seen;
        seen   = 0;
        nth_cl = 4'd0;
        for (int b = 7; b >= 2; b--) begin
            if (m[b]) begin
                if (seen == k) nth_cl = 4'(b);
                seen++;
            end
        end
    endfunction

    logic [7:0]          cur_mask, cur_rcd, cur_rp, cur_code;
    logic [8*N_SLOT-1:0] cur_tck;
    logic [3:0]          cur_cl;
    logic                slot_in_range, slot_live;
    int                  slot_idx;

    always_comb begin
        cur_mask      = mod_q ? cas_mask_b : cas_mask_a;
        cur_tck       = mod_q ? tck_b : tck_a;
        cur_rcd       = mod_q ? trcd_b : trcd_a;
        cur_rp        = mod_q ? trp_b : trp_a;
        slot_in_range = (int'(slot_q) < N_SLOT);
        slot_idx      = slot_in_range ? int'(slot_q) : 0;
        cur_code      = cur_tck[8*slot_idx +: 8];
        cur_cl        = nth_cl(cur_mask, slot_idx);
        slot_live     = slot_in_range && (cur_cl != 4'd0);
    end

    logic [PER_W-1:0] dec_period;
    logic [1:0]       dec_grade;
    logic             dec_bad;

    ddr2_tck_decode u_dec (
        .tck_code (cur_code),
        .period   (dec_period),
        .grade    (dec_grade),
        .bad      (dec_bad)
    );

    // ---- shared ceiling divider ----
    logic             div_go, div_fin;
    logic [NUM_W-1:0] div_num;
    logic [PER_W-1:0] div_den;
    logic [LAT_W-1:0] div_quo;

    always_comb begin
        div_go  = ((state_q == S_PREP) && slot_live && !dec_bad) ||
                  ((state_q == S_DIV_RCD) && div_fin);
        div_num = (state_q == S_PREP) ? NUM_W'(cur_rcd) * NUM_W'(25)
                                      : NUM_W'(cur_rp)  * NUM_W'(25);
        div_den = (state_q == S_PREP) ? dec_period : per_q;
    end

    ddr2_ceil_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    // ---- candidate under evaluation ----
    cand_t ev_a, ev_b, ev_c;
    logic  ev_take, last_pair, empty_mod;

    always_comb begin
        ev_a = cand_q[0][ei_q];
        ev_b = cand_q[1][ej_q];
        ev_c = ev_a;
        if (two_mods) begin
            ev_c.rcd = (ev_b.rcd > ev_a.rcd) ? ev_b.rcd : ev_a.rcd;
            ev_c.rp  = (ev_b.rp  > ev_a.rp)  ? ev_b.rp  : ev_a.rp;
        end
        last_pair = ((ei_q + 1'b1) == cnt_q[0]) &&
                    (!two_mods || ((ej_q + 1'b1) == cnt_q[1]));
        empty_mod = (cnt_q[0] == '0) || (two_mods && cnt_q[1] == '0);
    end

    ddr2_bin_judge u_judge (
        .cand      (ev_c),
        .best      (best_q),
        .have_best (have_q),
        .max_grade (max_grade),
        .two_mods  (two_mods),
        .take      (ev_take)
    );

    // ---- next-state logic ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_PREP;
            S_PREP: begin
                if (!slot_live) begin
                    if (!mod_q && two_mods) state_d = S_PREP;
                    else if (empty_mod)     state_d = S_FINISH;
                    else                    state_d = S_EVAL;
                end else if (dec_bad) begin
                    state_d = S_FINISH;
                end else begin
                    state_d = S_DIV_RCD;
                end
            end
            S_DIV_RCD: if (div_fin) state_d = S_DIV_RP;
            S_DIV_RP:  if (div_fin) state_d = S_PREP;
            S_EVAL:    if (last_pair) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---- datapath ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q   <= 1'b0;
            slot_q  <= '0;
            per_q   <= '0;
            grade_q <= '0;
            cl_q    <= '0;
            rcd_q   <= '0;
            ei_q    <= '0;
            ej_q    <= '0;
            have_q  <= 1'b0;
            bad_q   <= 1'b0;
            best_q  <= '0;
            for (int m = 0; m < 2; m++) begin
                cnt_q[m] <= '0;
                for (int s = 0; s < N_SLOT; s++) cand_q[m][s] <= '0;
            end
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    mod_q    <= 1'b0;
                    slot_q   <= '0;
                    ei_q     <= '0;
                    ej_q     <= '0;
                    have_q   <= 1'b0;
                    bad_q    <= 1'b0;
                    cnt_q[0] <= '0;
                    cnt_q[1] <= '0;
                end
                S_PREP: begin
                    if (!slot_live) begin
                        if (!mod_q && two_mods) begin
                            mod_q  <= 1'b1;
                            slot_q <= '0;
                        end
                    end else if (dec_bad) begin
                        bad_q <= 1'b1;
                    end else begin
                        per_q   <= dec_period;
                        grade_q <= dec_grade;
                        cl_q    <= cur_cl;
                    end
                end
                S_DIV_RCD: if (div_fin) rcd_q <= div_quo;
                S_DIV_RP: if (div_fin) begin
                    cand_q[mod_q][slot_q] <= '{grade: grade_q, cl: cl_q,
                                               rcd: rcd_q, rp: div_quo};
                    cnt_q[mod_q] <= slot_q + 1'b1;
                    slot_q       <= slot_q + 1'b1;
                end
                S_EVAL: begin
                    if (ev_take) begin
                        best_q <= ev_c;
                        have_q <= 1'b1;
                    end
                    if (two_mods) begin
                        if ((ej_q + 1'b1) == cnt_q[1]) begin
                            ej_q <= '0;
                            ei_q <= ei_q + 1'b1;
                        end else begin
                            ej_q <= ej_q + 1'b1;
                        end
                    end else begin
                        ei_q <= ei_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---- outputs ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            ok        <= 1'b0;
            fail      <= 1'b0;
            sel_grade <= '0;
            sel_cl    <= '0;
            sel_rcd   <= '0;
            sel_rp    <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == S_IDLE && start) begin
                ok   <= 1'b0;
                fail <= 1'b0;
            end else if (state_q == S_FINISH) begin
                done <= 1'b1;
                if (have_q && !bad_q) begin
                    ok        <= 1'b1;
                    fail      <= 1'b0;
                    sel_grade <= best_q.grade;
                    sel_cl    <= best_q.cl;
                    sel_rcd   <= best_q.rcd;
                    sel_rp    <= best_q.rp;
                end else begin
                    ok        <= 1'b0;
                    fail      <= 1'b1;
                    sel_grade <= '0;
                    sel_cl    <= '0;
                    sel_rcd   <= '0;
                    sel_rp    <= '0;
                end
            end
        end
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10 / R9: exactly one verdict accompanies completion
    a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok ^ fail));
    // R6: an accepted timing never breaks a rejection rule
    a_r6_rules_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> ((sel_cl > 4'd3) && (sel_grade <= max_grade) &&
                          !(two_mods && sel_grade == 2'd3)));
    // R3: a bad period never reaches evaluation
    a_r3_bad_skips_eval: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |-> (state_q != S_EVAL));
endmodule

// File: tb/ddr2_bin_picker_bench.sv
`timescale 1ns/1ps
module ddr2_bin_picker_bench;
    import ddr2_bin_pkg::*;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic two_mods = 1'b0;
    logic [1:0] max_grade = 2'd3;
    logic [7:0] m_mask [2];
    logic [7:0] m_tck  [2][NS];
    logic [7:0] m_rcd  [2];
    logic [7:0] m_rp   [2];
    logic done, ok, fail;
    logic [1:0] sel_grade;
    logic [3:0] sel_cl;
    logic [LAT_W-1:0] sel_rcd, sel_rp;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ddr2_bin_picker #(.N_SLOT(NS)) u_ddr2_bin_picker (
        .clk(clk), .rst_n(rst_n), .start(start), .two_mods(two_mods),
        .max_grade(max_grade),
        .cas_mask_a(m_mask[0]), .tck_a({m_tck[0][2], m_tck[0][1], m_tck[0][0]}),
        .trcd_a(m_rcd[0]), .trp_a(m_rp[0]),
        .cas_mask_b(m_mask[1]), .tck_b({m_tck[1][2], m_tck[1][1], m_tck[1][0]}),
        .trcd_b(m_rcd[1]), .trp_b(m_rp[1]),
        .done(done), .ok(ok), .fail(fail), .sel_grade(sel_grade),
        .sel_cl(sel_cl), .sel_rcd(sel_rcd), .sel_rp(sel_rp));

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dec_per(input int b);
        int lo, f;
        lo = b & 15;
        f  = (lo == 10) ? 25 : (lo == 11) ? 33 : (lo == 12) ? 66 :
             (lo == 13) ? 75 : 10 * lo;
        return 100 * (b >> 4) + f;
    endfunction

    function automatic int grade_of(input int p);
        return (p <= 250) ? 3 : (p <= 300) ? 2 : (p <= 375) ? 1 : 0;
    endfunction

    // behavioural reference
    task automatic model(output bit eok, output int eg, output int ecl,
                         output int er, output int ep);
        int cg[2][NS], ccl[2][NS], cr[2][NS], cp[2][NS], cn[2];
        bit bad, have;
        int bg, bcl, br, bp;
        bad = 0; have = 0; bg = 0; bcl = 0; br = 0; bp = 0;
        for (int m = 0; m < 2; m++) begin
            cn[m] = 0;
            if (m == 0 || two_mods) begin
                for (int b = 7; b >= 2; b--) begin
                    if (m_mask[m][b] && cn[m] < NS) begin
                        int p;
                        p = dec_per(int'(m_tck[m][cn[m]]));
                        if (p == 0 || p > 500) bad = 1;
                        else begin
                            cg[m][cn[m]]  = grade_of(p);
                            ccl[m][cn[m]] = b;
                            cr[m][cn[m]]  = (25 * int'(m_rcd[m]) + p - 1) / p;
                            cp[m][cn[m]]  = (25 * int'(m_rp[m]) + p - 1) / p;
                        end
                        cn[m]++;
                    end
                end
            end
        end
        if (!bad) begin
            for (int i = 0; i < cn[0]; i++) begin
                for (int j = 0; j < (two_mods ? cn[1] : 1); j++) begin
                    int g, c, r, q;
                    g = cg[0][i]; c = ccl[0][i]; r = cr[0][i]; q = cp[0][i];
                    if (two_mods) begin
                        if (cr[1][j] > r) r = cr[1][j];
                        if (cp[1][j] > q) q = cp[1][j];
                    end
                    if (!(g > int'(max_grade) || (two_mods && g == 3) || c <= 3)) begin
                        if (!have || g > bg || (g == bg && c + r + q <= bcl + br + bp)) begin
                            have = 1; bg = g; bcl = c; br = r; bp = q;
                        end
                    end
                end
            end
        end
        eok = have && !bad;
        eg = eok ? bg : 0; ecl = eok ? bcl : 0; er = eok ? br : 0; ep = eok ? bp : 0;
    endtask

    // one run; extra_start pulses start again while busy (R10)
    task automatic run(input string req, input bit extra_start);
        bit eok; int eg, ecl, er, ep, cyc, pulses;
        model(eok, eg, ecl, er, ep);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0; pulses = 0;
        while (!done && cyc < 5000) begin
            if (extra_start && cyc == 2) start = 1'b1;
            if (extra_start && cyc == 3) start = 1'b0;
            @(negedge clk); cyc++;
        end
        check(done == 1'b1, req, "done seen (watchdog)", int'(done), 1);
        if (done) begin
            check(ok == eok, req, "ok", int'(ok), int'(eok));
            check(fail == !eok, req, "fail", int'(fail), int'(!eok));
            check(int'(sel_grade) == eg && int'(sel_cl) == ecl, req, "grade*16+cl",
                  int'(sel_grade) * 16 + int'(sel_cl), eg * 16 + ecl);
            check(int'(sel_rcd) == er && int'(sel_rp) == ep, req, "rcd*1024+rp",
                  int'(sel_rcd) * 1024 + int'(sel_rp), er * 1024 + ep);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done) pulses++;
            end
            // R10: single pulse, results held
            check(pulses == 0 && ok == eok && int'(sel_cl) == ecl, "R10",
                  "held after done (extra pulses)", pulses, 0);
        end
    endtask

    task automatic set_mod(input int m, input logic [7:0] mask, input logic [7:0] t0,
                           input logic [7:0] t1, input logic [7:0] t2,
                           input logic [7:0] rcd, input logic [7:0] rp);
        m_mask[m] = mask; m_tck[m][0] = t0; m_tck[m][1] = t1; m_tck[m][2] = t2;
        m_rcd[m] = rcd; m_rp[m] = rp;
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] codes [10];
        codes = '{8'h25, 8'h2A, 8'h30, 8'h3B, 8'h3C, 8'h3D, 8'h50, 8'h18, 8'h51, 8'h3E};
        set_mod(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        set_mod(1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!done && !ok && !fail && sel_grade == 0 && sel_cl == 0 &&
              sel_rcd == 0 && sel_rp == 0, "R11", "reset outputs", int'(ok), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R8: grade 3 preferred; 1500/250 is exactly 6 (no round-up)
        set_mod(0, 8'h38, 8'h25, 8'h30, 8'h3D, 8'h3C, 8'h3C);
        two_mods = 0; max_grade = 2'd3;
        run("R2", 0);
        check(sel_grade == 2'd3 && sel_cl == 4'd5 && sel_rcd == 6 && sel_rp == 6,
              "R4", "explicit 800-5-6-6", int'(sel_rcd), 6);
        // R6 max grade limit
        max_grade = 2'd2; run("R6", 0);
        check(sel_grade == 2'd2 && sel_cl == 4'd4 && sel_rcd == 5, "R6",
              "explicit 667-4-5-5", int'(sel_grade), 2);
        // R6 two modules forbid grade 3, R7 merge takes larger delays
        max_grade = 2'd3; two_mods = 1;
        set_mod(1, 8'h30, 8'h30, 8'h3D, 8'h00, 8'h50, 8'h28);
        run("R7", 0);
        // R1 fractional codes 0xB, 0xC, 0xD and ceiling of 1250/333
        two_mods = 0;
        set_mod(0, 8'h70, 8'h3B, 8'h3C, 8'h3D, 8'h32, 8'h2D);
        run("R1", 0);
        set_mod(0, 8'h30, 8'h2A, 8'h3B, 8'h00, 8'h32, 8'h31);
        run("R1", 0);
        // R5 more than three bits set: only CL7,6,5 used
        set_mod(0, 8'hFC, 8'h25, 8'h30, 8'h3D, 8'h3C, 8'h3C);
        run("R5", 0);
        // R8 equal grade: lower sum wins
        set_mod(0, 8'h30, 8'h3D, 8'h3D, 8'h00, 8'h3C, 8'h3C);
        max_grade = 2'd1; run("R8", 0);
        max_grade = 2'd3;
        // R3 bad periods
        set_mod(0, 8'h30, 8'h30, 8'h51, 8'h00, 8'h3C, 8'h3C);
        run("R3", 0);
        set_mod(0, 8'h20, 8'h00, 8'h30, 8'h00, 8'h3C, 8'h3C);
        run("R3", 0);
        // R9 empty mask, all CL <= 3, empty second module
        set_mod(0, 8'h00, 8'h30, 8'h30, 8'h30, 8'h3C, 8'h3C);
        run("R9", 0);
        set_mod(0, 8'h0C, 8'h30, 8'h30, 8'h30, 8'h3C, 8'h3C);
        run("R9", 0);
        set_mod(0, 8'h10, 8'h30, 8'h30, 8'h30, 8'h3C, 8'h3C);
        set_mod(1, 8'h02, 8'h30, 8'h30, 8'h30, 8'h3C, 8'h3C);
        two_mods = 1; run("R9", 0);
        // R10 start while busy ignored
        set_mod(1, 8'h30, 8'h30, 8'h3D, 8'h00, 8'h50, 8'h28);
        run("R10", 1);
        // mixed patterns
        for (int t = 0; t < 40; t++) begin
            for (int m = 0; m < 2; m++)
                set_mod(m, 8'($urandom), codes[$urandom % 10], codes[$urandom % 10],
                        codes[$urandom % 10], 8'(8'h28 + $urandom % 40),
                        8'(8'h28 + $urandom % 40));
            two_mods = 1'($urandom);
            max_grade = 2'($urandom);
            run("R8", 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule